// File: doc/BRIEF.md
# I2C SCL Period Timer

This block produces the clock line of an I2C master from two programmable counts: one sets how long SCL is held low, the other how long it is left high. Both counts are in prescale ticks, which come from outside the block. The block drives SCL open-drain, so it only pulls the line low or releases it. It reads the line back through a synchronizer. A slave that stretches the clock, or a slow rise of the line, lengthens the period and does not shorten the high phase.

Each count is 9 bits. The low eight bits come from a count register. The ninth bit comes from a bit of the interrupt-enable register: bit 7 for the low count and bit 6 for the high count. A width option limits both counts to eight bits.

The byte engine raises `run_i` to ask for clocks. The timer first holds SCL released for one high count, which is the START hold time. It then toggles the line. It tells the engine when the line falls, so the engine can change SDA, and when a rising edge is confirmed, so the engine can sample SDA. When `run_i` is low at the end of a high phase, the timer returns to idle.

The state machine has five states:
- IDLE: SCL released, nothing counted.
- HOLD: SCL released, counting the high count for the START hold.
- LOW: SCL pulled low, counting the low count.
- WAIT_HI: SCL released, waiting for the synchronized line to read high.
- HIGH: SCL released, counting the high count.

Its transitions are:
- IDLE→HOLD on a run request.
- HOLD→LOW when the hold count expires.
- LOW→WAIT_HI when the low count expires and the synchronized line reads low.
- WAIT_HI→HIGH when the synchronized line reads high.
- HIGH→LOW when the count expires and `run_i` is high.
- HIGH→IDLE when the count expires and `run_i` is low.

Top module: `scl_period_timer`

## Requirements
- R1: After reset and while idle, `scl_oe_o` is 0 (line released) and neither strobe is asserted.
- R2: After `run_i` rises in idle, SCL stays released for exactly the effective high count in ticks before the first pull-low. With a tick every cycle, `fall_stb_o` appears H+1 cycles after the cycle in which `run_i` was set.
- R3: The low phase starts counting in the first cycle `scl_oe_o` is 1 and lasts the effective low count in ticks.
- R4: The high count starts only once the synchronized line reads high. With a prompt bus and SYNC_STAGES=2, there are 3 released cycles before `rise_stb_o`, followed by the high count in ticks.
- R5: While the line is held low externally after release, no rising strobe occurs and the high count does not start. A hold released S cycles into WAIT_HI yields S+3 released cycles before `rise_stb_o`.
- R6: With `wide_en_i`=1, the low count is {`lo_cnt_b8_i`, `lo_cnt_i`} and the high count is {`hi_cnt_b8_i`, `hi_cnt_i`}, each 9 bits.
- R7: With `wide_en_i`=0, `lo_cnt_b8_i` and `hi_cnt_b8_i` are ignored and both counts are limited to 8 bits.
- R8: A count value of 0 acts as 1.
- R9: Counts advance only in cycles where `tick_i` is 1.
- R10: `fall_stb_o` is a one-cycle pulse in the first cycle of each low phase. `rise_stb_o` is a one-cycle pulse in the first cycle of each high phase. The two never coincide.
- R11: If `run_i` is 1 at the end of a high phase, the next low phase follows at once. If it is 0, the timer goes idle with SCL released.
- R12: A low phase never ends before the synchronized line reads low. With a tick every cycle, a low count of 1 or 2 gives 3 low cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| tick_i | input | 1 | Prescale tick; one count unit per tick |
| run_i | input | 1 | Clock request from the byte engine |
| lo_cnt_i | input | 8 | Low count, bits 7..0 |
| hi_cnt_i | input | 8 | High count, bits 7..0 |
| lo_cnt_b8_i | input | 1 | Low count bit 8 (interrupt-enable register bit 7) |
| hi_cnt_b8_i | input | 1 | High count bit 8 (interrupt-enable register bit 6) |
| wide_en_i | input | 1 | 1: 9-bit counts, 0: 8-bit counts |
| scl_i | input | 1 | SCL line as seen at the pad |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_stb_o | output | 1 | Pulse on each falling SCL edge |
| rise_stb_o | output | 1 | Pulse on each confirmed rising SCL edge |

## Verification
With a tick every cycle, `fall_stb_o` is due H+1 cycles after the bench sets `run_i`. `scl_oe_o` then stays high for L cycles, or for 3 cycles when L is below 3. `rise_stb_o` is due 3 cycles after release, plus any stretch, and the next `fall_stb_o` follows H cycles later.

The bench drives inputs and samples outputs on falling clock edges, so each sample lands in one known cycle. It counts cycles and ticks between these strobe points rather than waiting for events. With a slower tick it counts the ticks seen inside each phase, which makes the result independent of the tick phase.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_LOW,
        PH_WAIT_HI,
        PH_HIGH
    } scl_phase_e;

    function automatic logic phase_counted(input scl_phase_e ph);
        return (ph == PH_HOLD) || (ph == PH_LOW) || (ph == PH_HIGH);
    endfunction

endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '1;
                else         chain_q <= line_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '1;
                else         chain_q <= {chain_q[STAGES-2:0], line_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/scl_cnt_merge.sv
module scl_cnt_merge #(
    parameter int REG_W = 8,
    localparam int CNT_W = REG_W + 1
) (
    input  logic [REG_W-1:0] base_i,
    input  logic             msb_i,
    input  logic             wide_en_i,
    output logic [CNT_W-1:0] eff_o
);
    logic [CNT_W-1:0] raw;

    assign raw   = {wide_en_i & msb_i, base_i};
    assign eff_o = (raw == '0) ? CNT_W'(1) : raw;
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= CNT_W'(1);
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q > CNT_W'(1))) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last_o = tick_i && (cnt_q == CNT_W'(1));

    // R8
    load_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |-> (load_val_i != '0));

    // R8
    cnt_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q != '0);
endmodule

// File: rtl/scl_period_timer.sv
module scl_period_timer
    import scl_timer_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = REG_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic [REG_W-1:0] lo_cnt_i,
    input  logic [REG_W-1:0] hi_cnt_i,
    input  logic             lo_cnt_b8_i,
    input  logic             hi_cnt_b8_i,
    input  logic             wide_en_i,
    input  logic             scl_i,
    output logic             scl_oe_o,
    output logic             fall_stb_o,
    output logic             rise_stb_o
);
    scl_phase_e       phase_q, phase_d;
    logic             scl_hi;
    logic [CNT_W-1:0] lo_eff, hi_eff, load_val;
    logic             load, cnt_last;

    scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (scl_i),
        .sync_o (scl_hi)
    );

    scl_cnt_merge #(.REG_W(REG_W)) u_lo_merge (
        .base_i    (lo_cnt_i),
        .msb_i     (lo_cnt_b8_i),
        .wide_en_i (wide_en_i),
        .eff_o     (lo_eff)
    );

    scl_cnt_merge #(.REG_W(REG_W)) u_hi_merge (
        .base_i    (hi_cnt_i),
        .msb_i     (hi_cnt_b8_i),
        .wide_en_i (wide_en_i),
        .eff_o     (hi_eff)
    );

    scl_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .load_val_i (load_val),
        .tick_i     (tick_i),
        .last_o     (cnt_last)
    );

    // next phase
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:    if (run_i)                phase_d = PH_HOLD;
            PH_HOLD:    if (cnt_last)             phase_d = PH_LOW;
            PH_LOW:     if (cnt_last && !scl_hi)  phase_d = PH_WAIT_HI;
            PH_WAIT_HI: if (scl_hi)               phase_d = PH_HIGH;
            PH_HIGH:    if (cnt_last)             phase_d = run_i ? PH_LOW : PH_IDLE;
            default:                              phase_d = PH_IDLE;
        endcase
    end

    assign load     = (phase_d != phase_q) && phase_counted(phase_d);
    assign load_val = (phase_d == PH_LOW) ? lo_eff : hi_eff;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) phase_q <= PH_IDLE;
        else         phase_q <= phase_d;
    end

    // outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fall_stb_o <= 1'b0;
            rise_stb_o <= 1'b0;
        end else begin
            fall_stb_o <= (phase_d == PH_LOW)  && (phase_q != PH_LOW);
            rise_stb_o <= (phase_d == PH_HIGH) && (phase_q != PH_HIGH);
        end
    end

    assign scl_oe_o = (phase_q == PH_LOW);

    // R1
    idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q == PH_IDLE) |-> (!scl_oe_o && !rise_stb_o));

    // R10
    fall_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(scl_oe_o) |-> fall_stb_o);

    // R10
    fall_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_stb_o |-> scl_oe_o);

    // R10
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(fall_stb_o && rise_stb_o));

    // R4
    rise_needs_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_stb_o |-> (scl_hi && !scl_oe_o));

    // R5
    stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q == PH_WAIT_HI && !scl_hi) |=> (phase_q != PH_HIGH));

    // R12
    low_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(scl_oe_o) |-> !$past(scl_hi));

    // R7
    narrow_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wide_en_i |-> (!lo_eff[CNT_W-1] && !hi_eff[CNT_W-1]));
endmodule

// File: tb/scl_period_timer_tb_top.sv
`timescale 1ns/1ps
module scl_period_timer_tb_top;
    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b1, run = 1'b0;
    logic       wide = 1'b1, lo_b8 = 1'b0, hi_b8 = 1'b0, stretch = 1'b0;
    logic [7:0] lo_cnt = 8'd5, hi_cnt = 8'd4;
    logic       scl_oe, fall_stb, rise_stb, scl_line;
    int         tick_div = 1, tick_ph = 0;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    assign scl_line = !scl_oe && !stretch;

    scl_period_timer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .run_i(run),
        .lo_cnt_i(lo_cnt), .hi_cnt_i(hi_cnt),
        .lo_cnt_b8_i(lo_b8), .hi_cnt_b8_i(hi_b8), .wide_en_i(wide),
        .scl_i(scl_line), .scl_oe_o(scl_oe),
        .fall_stb_o(fall_stb), .rise_stb_o(rise_stb)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            if (tick_div <= 1) begin
                tick <= 1'b1;
                tick_ph = 0;
            end else begin
                tick <= (tick_ph == 0);
                tick_ph = (tick_ph + 1) % tick_div;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic start_clock(input string req, input int exp_ticks, input int exp_k);
        int k = 0, ht = 0, oe_seen = 0;
        run = 1'b1;
        while (k < 6000) begin
            @(negedge clk);
            k++;
            if (fall_stb) break;
            if (tick) ht++;
            if (scl_oe) oe_seen++;
        end
        check(ht == exp_ticks, req, "hold ticks", ht, exp_ticks);
        check(oe_seen == 0, req, "pull-low during hold", oe_seen, 0);
        if (exp_k >= 0) check(k == exp_k, req, "cycles to first fall", k, exp_k);
    endtask

    task automatic one_period(input int s, output int lc, output int lt, output int gap,
                              output int hc, output int ht, output int fp, output int rp);
        lc = 0; lt = 0; gap = 0; hc = 0; ht = 0; fp = 0; rp = 0;
        stretch = (s > 0);
        while (scl_oe && lc < 6000) begin
            lc++;
            if (tick) lt++;
            if (fall_stb) fp++;
            @(negedge clk);
        end
        while (!rise_stb && gap < 6000) begin
            if (gap == s) stretch = 1'b0;
            gap++;
            @(negedge clk);
        end
        while (!fall_stb && hc < 6000) begin
            hc++;
            if (tick) ht++;
            if (rise_stb) rp++;
            @(negedge clk);
        end
    endtask

    task automatic stop_clock(input string req);
        int g = 0, oe_n = 0, f_n = 0;
        run = 1'b0;
        while (!rise_stb && g < 6000) begin
            g++;
            @(negedge clk);
        end
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (scl_oe) oe_n++;
            if (fall_stb) f_n++;
        end
        check(oe_n == 0, req, "pull-low after stop", oe_n, 0);
        check(f_n == 0, req, "fall strobes after stop", f_n, 0);
    endtask

    task automatic t_reset();
        int bad_oe = 0, bad_stb = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (scl_oe) bad_oe++;
            if (fall_stb || rise_stb) bad_stb++;
        end
        check(bad_oe == 0, "R1", "oe while idle", bad_oe, 0);
        check(bad_stb == 0, "R1", "strobes while idle", bad_stb, 0);
    endtask

    task automatic t_basic();
        int lc, lt, gap, hc, ht, fp, rp;
        lo_cnt = 8'd5; hi_cnt = 8'd4; wide = 1'b1; lo_b8 = 1'b0; hi_b8 = 1'b0; tick_div = 1;
        start_clock("R2", 4, 5);
        check(scl_oe == 1'b1, "R10", "oe at fall strobe", int'(scl_oe), 1);
        one_period(0, lc, lt, gap, hc, ht, fp, rp);
        check(lc == 5, "R3", "low cycles", lc, 5);
        check(gap == 3, "R4", "release to rise", gap, 3);
        check(hc == 4, "R4", "high cycles", hc, 4);
        check(fp == 1, "R10", "fall pulse width", fp, 1);
        check(rp == 1, "R10", "rise pulse width", rp, 1);
        one_period(0, lc, lt, gap, hc, ht, fp, rp);
        check(lc == 5 && hc == 4, "R11", "second period low+high", lc + hc, 9);
        stop_clock("R11");
    endtask

    task automatic t_prescale();
        int lc, lt, gap, hc, ht, fp, rp;
        lo_cnt = 8'd3; hi_cnt = 8'd6; tick_div = 4;
        start_clock("R9", 6, -1);
        one_period(0, lc, lt, gap, hc, ht, fp, rp);
        check(lt == 3, "R9", "low ticks", lt, 3);
        check(ht == 6, "R9", "high ticks", ht, 6);
        check(lc > lt, "R9", "low cycles exceed ticks", lc, lt);
        stop_clock("R11");
        tick_div = 1;
    endtask

    task automatic t_bit8();
        int lc, lt, gap, hc, ht, fp, rp;
        lo_cnt = 8'd5; hi_cnt = 8'd4; wide = 1'b1; lo_b8 = 1'b1; hi_b8 = 1'b1;
        start_clock("R6", 260, 261);
        one_period(0, lc, lt, gap, hc, ht, fp, rp);
        check(lc == 261, "R6", "9-bit low", lc, 261);
        check(hc == 260, "R6", "9-bit high", hc, 260);
        stop_clock("R11");
    endtask

    task automatic t_narrow();
        int lc, lt, gap, hc, ht, fp, rp;
        wide = 1'b0; lo_b8 = 1'b1; hi_b8 = 1'b1;
        start_clock("R7", 4, 5);
        one_period(0, lc, lt, gap, hc, ht, fp, rp);
        check(lc == 5, "R7", "bit 8 ignored low", lc, 5);
        check(hc == 4, "R7", "bit 8 ignored high", hc, 4);
        stop_clock("R11");
        wide = 1'b1; lo_b8 = 1'b0; hi_b8 = 1'b0;
    endtask

    task automatic t_zero();
        int lc, lt, gap, hc, ht, fp, rp;
        lo_cnt = 8'd0; hi_cnt = 8'd0;
        start_clock("R8", 1, 2);
        one_period(0, lc, lt, gap, hc, ht, fp, rp);
        check(lc == 3, "R12", "short low waits for line", lc, 3);
        check(hc == 1, "R8", "zero high acts as one", hc, 1);
        stop_clock("R11");
    endtask

    task automatic t_stretch();
        int lc, lt, gap, hc, ht, fp, rp;
        lo_cnt = 8'd4; hi_cnt = 8'd3;
        start_clock("R2", 3, 4);
        one_period(7, lc, lt, gap, hc, ht, fp, rp);
        check(lc == 4, "R3", "low with stretch armed", lc, 4);
        check(gap == 10, "R5", "stretched release to rise", gap, 10);
        check(hc == 3, "R5", "high after stretch", hc, 3);
        check(rp == 1, "R5", "one rise strobe", rp, 1);
        stop_clock("R11");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(!scl_oe && !fall_stb && !rise_stb, "R1", "outputs in reset",
              int'({scl_oe, fall_stb, rise_stb}), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_prescale();
        t_bit8();
        t_narrow();
        t_zero();
        t_stretch();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule